// File: doc/BRIEF.md
# Scanned Two-Score Display Driver with Turn Marker

This block drives a bank of six seven-segment digits that share one set of segment lines. It lights one digit at a time and moves on to the next after a fixed number of clocks. Two player scores arrive as packed two-digit BCD bytes. The first player's score appears on the two leftmost digits and the second player's score on the two rightmost digits.

The two middle digits act as a turn marker. A single dash appears on the middle digit nearest the player whose move it is, and the other middle digit stays dark. The scan runs on its own from reset onward. It needs no request or acknowledge from the game logic, so new scores or a new turn show up the next time their digit is scanned.

Top module: `scoreboard_scan`

## Requirements
- R1: While `rst` is high at a rising clock edge, `digit_sel` becomes 0. After `rst` is released, the scan starts from digit 0.
- R2: Each digit stays selected for exactly `HOLD_CLKS` consecutive clocks before the select changes.
- R3: `digit_sel` steps 0,1,2,3,4,5 and then wraps back to 0. It never takes the values 6 or 7.
- R4: Digit 0 shows the upper nibble of `score_p1` (tens) and digit 1 shows its lower nibble (ones).
- R5: Digit 4 shows the upper nibble of `score_p2` (tens) and digit 5 shows its lower nibble (ones).
- R6: With `turn_p2` = 0, digit 2 shows the dash and digit 3 is dark. With `turn_p2` = 1, digit 3 shows the dash and digit 2 is dark. Dark means `seg_out` = 8'h00.
- R7: The dash pattern lights only segment g, so `seg_out` = 8'h40.
- R8: A score nibble with a value above 9 is shown dark (8'h00) on its digit.
- R9: Bit 7 of `seg_out` (the decimal point) is always 0.
- R10: Segments are active high, with bit 0 = a through bit 6 = g. The digit codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| score_p1 | input | 8 | First player's score, two BCD digits (tens in bits 7:4) |
| score_p2 | input | 8 | Second player's score, two BCD digits (tens in bits 7:4) |
| turn_p2 | input | 1 | 0 when the first player is to move, 1 when the second player is to move |
| seg_out | output | 8 | Segment pattern of the selected digit, active high, bit 7 decimal point |
| digit_sel | output | 3 | Index of the digit currently lit, 0 leftmost |

## Verification
The segment checks compare `seg_out` against the inputs in the same cycle. This holds because the segment path is combinational from the registered select, and it means the scores and the turn bit may change at any clock without breaking an assertion. The scan-order and hold-length properties assume only that reset is synchronous and is sampled at the clock edge. The stimulus changes scores, the turn bit and reset just after a rising edge and samples outputs at the falling edge. This keeps every comparison clear of the edge, including when the turn flips in the middle of a digit's hold period and when reset arrives in the middle of a scan.

// File: rtl/scoreboard_pkg.sv
package scoreboard_pkg;

    localparam int NUM_DIGITS = 6;
    localparam int SEL_W      = 3;

    // Digit positions, left to right; the scan order depends on them.
    localparam logic [SEL_W-1:0] POS_P1_TENS = 3'd0;
    localparam logic [SEL_W-1:0] POS_P1_ONES = 3'd1;
    localparam logic [SEL_W-1:0] POS_MID_L   = 3'd2;
    localparam logic [SEL_W-1:0] POS_MID_R   = 3'd3;
    localparam logic [SEL_W-1:0] POS_P2_TENS = 3'd4;
    localparam logic [SEL_W-1:0] POS_P2_ONES = 3'd5;

    localparam logic [6:0] SEGS_DARK = 7'h00;
    localparam logic [6:0] SEGS_DASH = 7'h40;  // segment g alone

    typedef enum logic [1:0] {
        GLYPH_DARK  = 2'd0,
        GLYPH_DIGIT = 2'd1,
        GLYPH_DASH  = 2'd2
    } glyph_kind_e;

    typedef struct packed {
        glyph_kind_e kind;
        logic [3:0]  value;
    } glyph_t;

    // Segment lines g..a for a decimal digit; anything else stays dark.
    function automatic logic [6:0] bcd_to_segs(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEGS_DARK;
        endcase
        return s;
    endfunction

    // A nibble becomes a digit glyph only when it is a legal BCD value.
    function automatic glyph_t glyph_from_nibble(input logic [3:0] v);
        glyph_t g;
        g.value = v;
        g.kind  = (v <= 4'd9) ? GLYPH_DIGIT : GLYPH_DARK;
        return g;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
    import scoreboard_pkg::*;
#(
    parameter int HOLD_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEL_W-1:0] digit_sel
);

    localparam int TICK_W = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST  = TICK_W'(HOLD_CLKS - 1);
    localparam logic [SEL_W-1:0]  DIGIT_LAST = SEL_W'(NUM_DIGITS - 1);

    logic [TICK_W-1:0] tick_q;
    logic [SEL_W-1:0]  digit_q;
    logic              step;

    assign step = (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            digit_q <= '0;
        end else if (step) begin
            tick_q  <= '0;
            digit_q <= (digit_q == DIGIT_LAST) ? '0 : digit_q + SEL_W'(1);
        end else begin
            tick_q  <= tick_q + TICK_W'(1);
        end
    end

    assign digit_sel = digit_q;

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        digit_q <= DIGIT_LAST);  // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(digit_q));  // R2

    AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (step && digit_q != DIGIT_LAST) |=> digit_q == $past(digit_q) + SEL_W'(1));  // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && digit_q == DIGIT_LAST) |=> digit_q == '0);  // R3

endmodule

// File: rtl/glyph_select.sv
module glyph_select
    import scoreboard_pkg::*;
(
    input  logic [SEL_W-1:0] digit_sel,
    input  logic [7:0]       score_p1,
    input  logic [7:0]       score_p2,
    input  logic             turn_p2,
    output glyph_t           glyph
);

    glyph_t marker;

    always_comb begin
        marker.value = 4'd0;
        marker.kind  = GLYPH_DARK;
    end

    always_comb begin
        case (digit_sel)
            POS_P1_TENS: glyph = glyph_from_nibble(score_p1[7:4]);
            POS_P1_ONES: glyph = glyph_from_nibble(score_p1[3:0]);
            POS_MID_L: begin
                glyph      = marker;
                glyph.kind = turn_p2 ? GLYPH_DARK : GLYPH_DASH;
            end
            POS_MID_R: begin
                glyph      = marker;
                glyph.kind = turn_p2 ? GLYPH_DASH : GLYPH_DARK;
            end
            POS_P2_TENS: glyph = glyph_from_nibble(score_p2[7:4]);
            POS_P2_ONES: glyph = glyph_from_nibble(score_p2[3:0]);
            default:     glyph = marker;
        endcase
    end

endmodule

// File: rtl/seg_drive.sv
module seg_drive
    import scoreboard_pkg::*;
(
    input  glyph_t     glyph,
    output logic [7:0] seg_out
);

    logic [6:0] body;

    always_comb begin
        case (glyph.kind)
            GLYPH_DIGIT: body = bcd_to_segs(glyph.value);
            GLYPH_DASH:  body = SEGS_DASH;
            default:     body = SEGS_DARK;
        endcase
    end

    // Decimal point held off.
    assign seg_out = {1'b0, body};

endmodule

// File: rtl/scoreboard_scan.sv
module scoreboard_scan
    import scoreboard_pkg::*;
#(
    parameter int HOLD_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] score_p1,
    input  logic [7:0] score_p2,
    input  logic       turn_p2,
    output logic [7:0] seg_out,
    output logic [2:0] digit_sel
);

    logic [SEL_W-1:0] sel_w;
    glyph_t           glyph_w;

    scan_timer #(.HOLD_CLKS(HOLD_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .digit_sel (sel_w)
    );

    glyph_select u_select (
        .digit_sel (sel_w),
        .score_p1  (score_p1),
        .score_p2  (score_p2),
        .turn_p2   (turn_p2),
        .glyph     (glyph_w)
    );

    seg_drive u_drive (
        .glyph   (glyph_w),
        .seg_out (seg_out)
    );

    assign digit_sel = sel_w;

    AST_DP_DARK: assert property (@(posedge clk) disable iff (rst)
        seg_out[7] == 1'b0);  // R9

    AST_DASH_LEFT: assert property (@(posedge clk) disable iff (rst)
        (digit_sel == POS_MID_L && !turn_p2) |-> seg_out == 8'h40);  // R6

    AST_DASH_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (digit_sel == POS_MID_R && turn_p2) |-> seg_out == 8'h40);  // R7

    AST_MID_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((digit_sel == POS_MID_L && turn_p2) || (digit_sel == POS_MID_R && !turn_p2))
        |-> seg_out == 8'h00);  // R6

    AST_BAD_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (digit_sel == POS_P2_ONES && score_p2[3:0] > 4'd9) |-> seg_out == 8'h00);  // R8

endmodule

// File: tb/sim_scoreboard_scan.sv
module sim_scoreboard_scan;

    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] s1  = 8'h00;
    logic [7:0] s2  = 8'h00;
    logic       turn = 1'b0;
    logic [7:0] seg;
    logic [2:0] sel;

    scoreboard_scan #(.HOLD_CLKS(HOLD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .score_p1  (s1),
        .score_p2  (s2),
        .turn_p2   (turn),
        .seg_out   (seg),
        .digit_sel (sel)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int failures = 0;
    int m_digit = 0;
    int m_tick = 0;
    bit m_live = 1'b0;
    bit done = 1'b0;
    int run_len = 0;
    int prev_sel = 0;
    bit run_clean = 1'b0;

    // Behavioural scan model, advanced on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_digit = 0;
            m_tick  = 0;
        end else if (m_tick == HOLD - 1) begin
            m_tick  = 0;
            m_digit = (m_digit == 5) ? 0 : m_digit + 1;
        end else begin
            m_tick = m_tick + 1;
        end
        m_live = 1'b1;
    end

    function automatic logic [7:0] digit_code(input logic [3:0] n);
        case (n)
            4'd0: return 8'h3F;  4'd1: return 8'h06;
            4'd2: return 8'h5B;  4'd3: return 8'h4F;
            4'd4: return 8'h66;  4'd5: return 8'h6D;
            4'd6: return 8'h7D;  4'd7: return 8'h07;
            4'd8: return 8'h7F;  4'd9: return 8'h6F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] shown_nibble(input int d);
        case (d)
            0: return s1[7:4];
            1: return s1[3:0];
            4: return s2[7:4];
            default: return s2[3:0];
        endcase
    endfunction

    function automatic logic [7:0] expect_seg(input int d);
        if (d == 2) return turn ? 8'h00 : 8'h40;
        if (d == 3) return turn ? 8'h40 : 8'h00;
        return digit_code(shown_nibble(d));
    endfunction

    function automatic string tag_for(input int d);
        if (d == 2 || d == 3) return "R6 R7";
        if (shown_nibble(d) > 4'd9) return "R8";
        if (d < 2) return "R4 R10";
        return "R5 R10";
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && !done) begin
            check(sel == 3'(m_digit), rst ? "R1" : "R2 R3", "digit_sel", sel, m_digit);
            if (!rst)
                check(seg == expect_seg(m_digit), tag_for(m_digit), "seg_out",
                      seg, expect_seg(m_digit));
            check(seg[7] == 1'b0, "R9", "decimal point", seg[7], 0);
            if (rst) begin
                run_clean = 1'b0;
                run_len   = 0;
                prev_sel  = 0;
            end else if (int'(sel) != prev_sel) begin
                if (run_clean) check(run_len == HOLD, "R2", "hold length", run_len, HOLD);
                run_clean = 1'b1;
                run_len   = 1;
                prev_sel  = int'(sel);
            end else begin
                run_len++;
            end
        end
    end

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic t);
        @(posedge clk);
        #1;
        s1   = a;
        s2   = b;
        turn = t;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        wait_clks(3);
        #1 rst = 1'b0;
        // R4 R5 R6: sweep every decimal value over both scores and both turns.
        for (int k = 0; k < 10; k++) begin
            apply({4'(k), 4'(9 - k)}, {4'((k + 3) % 10), 4'((k + 7) % 10)}, k[0]);
            wait_clks(2 * 6 * HOLD);
        end
        // R8: nibbles above 9 on every score digit.
        apply(8'hAF, 8'hB9, 1'b0);
        wait_clks(6 * HOLD);
        apply(8'h9C, 8'hDE, 1'b1);
        wait_clks(6 * HOLD);
        // R1: reset in the middle of a scan.
        apply(8'h42, 8'h17, 1'b0);
        wait_clks(13);
        #1 rst = 1'b1;
        wait_clks(2);
        #1 rst = 1'b0;
        wait_clks(6 * HOLD);
        // R6: turn flips in the middle of a digit's hold period.
        for (int k = 0; k < 12; k++) begin
            apply(8'h05, 8'h63, k[0]);
            wait_clks(7);
        end
        wait_clks(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clks(100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule